// File: doc/BRIEF.md
# Programmable Binary Neural Classifier

This block sorts an 8-bit binary pattern into one of four steering classes (left turn, right turn, stop, U-turn) with a two-layer binary neural network. Neither layer multiplies. Each neuron XNORs its input vector with a stored weight and counts how many bit positions agree. It fires when that count reaches half the vector width. The first layer has eight neurons that see the full 8-bit input. The second layer has four neurons whose input is the outputs of first-layer neurons 0 to 3. Each second-layer neuron drives one class bit.

The weights sit in registers. Reset fills them with built-in values, and software can overwrite any of them while the block is running. A load sequencer takes one 4-bit nibble per clock from the upper half of the bidirectional port. It does so only on cycles where the port's enable bit is set. It places the nibble in the weight slot its counter points at, then moves the counter on. The result is registered on every clock. The lower four result bits carry the classes. The upper four bits show first-layer neurons 0 to 3 for debug.

Top module: `bnn_classifier`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result` becomes 0x00, the load slot counter returns to slot 0 and all weights take their defaults.
- R2: First-layer neuron i outputs 1 when at least 4 of the 8 bit positions of `data_in` match its weight.
- R3: Second-layer neuron k outputs 1 when at least 2 of its 4 weight bits match the vector {n3,n2,n1,n0} of first-layer outputs. Bit j of that vector is neuron j.
- R4: At each rising edge, `result[3:0]` takes second-layer neurons 3..0 and `result[7:4]` takes first-layer neurons 3..0, both computed from the `data_in` and weights present just before that edge.
- R5: On an edge with `bidir_in[3]`=1, the nibble `bidir_in[7:4]` is written to the current slot and the counter advances. Slots 2i and 2i+1 are the low and high nibbles of first-layer weight i (i=0..7). Slots 16+k hold second-layer weight k (k=0..3).
- R6: On an edge with `bidir_in[3]`=0, the slot counter and all weights keep their values, whatever `bidir_in[7:4]` holds.
- R7: After a nibble is written to slot 19, the next enabled write goes to slot 0.
- R8: `bidir_oe` and `bidir_out` are always 0x00, so the port is an input only.
- R9: The default first-layer weight i is 0x0F rotated left by i bits. The default second-layer weight k is 4'b0011 rotated left by k bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 8 | Pattern to classify |
| bidir_in | input | 8 | Bidirectional port input side: bit 3 is the load enable, bits 7:4 are the load nibble |
| bidir_out | output | 8 | Bidirectional port output side, held at zero |
| bidir_oe | output | 8 | Bidirectional port output enables, held at zero |
| result | output | 8 | Registered classes in bits 3:0 and debug neurons 3..0 in bits 7:4 |

## Verification
The assertions check on every cycle how the slot counter moves: it stays in range, steps by one, wraps after the last slot and freezes when the enable is low. They also check that the weights cannot change while the enable is low. Both halves of `result` are checked against the previous cycle's neuron outputs. Whether the popcount thresholds are right, whether defaults are restored and whether each nibble lands in its slot can only be shown by the bench. It compares the classifications against a reference model across default weights, a full reload, a paused reload, a counter wrap and a reset in the middle of a load.

// File: rtl/bnn_pkg.sv
// Shared helpers for the binary neural classifier.
// Assumes weights are at most 32 bits wide.
package bnn_pkg;

    // Default weight: lower half of the bits set, rotated left by idx.
    function automatic logic [31:0] rot_weight(input int width, input int idx);
        logic [31:0] r;
        r = '0;
        for (int b = 0; b < width; b++) begin
            r[b] = ((((b - idx) % width) + width) % width) < (width / 2);
        end
        return r;
    endfunction

endpackage

// File: rtl/bnn_neuron.sv
// One binary neuron: XNOR of input and weight, popcount, then a threshold.
// Assumes TH <= W. Purely combinational.
module bnn_neuron #(
    parameter int W  = 8,
    parameter int TH = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] w,
    output logic         fire
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  agree;
    logic [CW-1:0] cnt;

    // Mark every bit position where input and weight agree.
    assign agree = ~(x ^ w);

    // Count the agreeing positions.
    always_comb begin
        cnt = '0;
        for (int b = 0; b < W; b++) begin
            cnt = cnt + CW'(agree[b]);
        end
    end

    // Fire once the count reaches the threshold.
    assign fire = (cnt >= CW'(TH));

endmodule

// File: rtl/bnn_layer.sv
// A layer of N neurons that share one input vector.
// Weights arrive flattened, with neuron i in bits [i*W +: W].
module bnn_layer #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int TH = W / 2
) (
    input  logic [W-1:0]   x,
    input  logic [N*W-1:0] w_flat,
    output logic [N-1:0]   fire
);
    // One neuron instance per output bit.
    for (genvar i = 0; i < N; i++) begin : g_neuron
        bnn_neuron #(.W(W), .TH(TH)) u_neuron (
            .x    (x),
            .w    (w_flat[i*W +: W]),
            .fire (fire[i])
        );
    end

endmodule

// File: rtl/bnn_weight_loader.sv
// Weight store and nibble-serial load sequencer.
// Every weight is split into NIB_W-bit slots. First-layer slots come first,
// neuron 0 first and low nibble first within a weight, then second-layer slots.
// Each enabled cycle writes the current slot and advances the counter.
// After the last slot the counter wraps to slot 0.
// Assumes both weight widths are multiples of NIB_W.
module bnn_weight_loader #(
    parameter int L1_N  = 8,
    parameter int L1_W  = 8,
    parameter int L2_N  = 4,
    parameter int L2_W  = 4,
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [NIB_W-1:0]     load_nib,
    output logic [L1_N*L1_W-1:0] l1_w_flat,
    output logic [L2_N*L2_W-1:0] l2_w_flat
);
    localparam int NPW1     = L1_W / NIB_W;
    localparam int NPW2     = L2_W / NIB_W;
    localparam int L1_SLOTS = L1_N * NPW1;
    localparam int TOTAL    = L1_SLOTS + L2_N * NPW2;
    localparam int SLOT_W   = $clog2(TOTAL);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(TOTAL - 1);

    logic [SLOT_W-1:0] slot;
    logic [NIB_W-1:0]  nib [TOTAL];

    // Default contents of one slot, taken from the rotated default weights.
    function automatic logic [NIB_W-1:0] def_nib(input int s);
        logic [31:0] w;
        if (s < L1_SLOTS) begin
            w = bnn_pkg::rot_weight(L1_W, s / NPW1);
            return NIB_W'(w >> ((s % NPW1) * NIB_W));
        end else begin
            w = bnn_pkg::rot_weight(L2_W, (s - L1_SLOTS) / NPW2);
            return NIB_W'(w >> (((s - L1_SLOTS) % NPW2) * NIB_W));
        end
    endfunction

    // Slot counter: step on each enabled cycle, wrap after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (load_en) begin
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
        end
    end

    // Weight store: load defaults on reset, write the current slot when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < TOTAL; s++) begin
                nib[s] <= def_nib(s);
            end
        end else if (load_en) begin
            nib[slot] <= load_nib;
        end
    end

    // Gather the first-layer slots into flattened weights.
    for (genvar i = 0; i < L1_N; i++) begin : g_l1
        for (genvar j = 0; j < NPW1; j++) begin : g_nib
            assign l1_w_flat[i*L1_W + j*NIB_W +: NIB_W] = nib[i*NPW1 + j];
        end
    end

    // Gather the second-layer slots into flattened weights.
    for (genvar k = 0; k < L2_N; k++) begin : g_l2
        for (genvar j = 0; j < NPW2; j++) begin : g_nib
            assign l2_w_flat[k*L2_W + j*NIB_W +: NIB_W] = nib[L1_SLOTS + k*NPW2 + j];
        end
    end

    // R7
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST);

    // R7
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && slot == LAST) |=> (slot == '0));

    // R5
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && slot != LAST) |=> (slot == $past(slot) + 1'b1));

    // R6
    load_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(slot) && $stable(l1_w_flat) && $stable(l2_w_flat)));

endmodule

// File: rtl/bnn_classifier.sv
// Two-layer binary neural classifier with weights that can be reloaded.
// Both layers are combinational from data_in. The result is registered on
// every clock. The second layer reads first-layer neurons 0..L2_IN-1, and the
// debug bits mirror the same neurons. Weight nibbles enter on
// bidir_in[DATA_LSB +: NIB_W] while bidir_in[EN_BIT] is high.
// The bidirectional port never drives.
module bnn_classifier #(
    parameter int IN_W     = 8,
    parameter int L1_N     = 8,
    parameter int L2_IN    = 4,
    parameter int L2_N     = 4,
    parameter int NIB_W    = 4,
    parameter int BIDIR_W  = 8,
    parameter int EN_BIT   = 3,
    parameter int DATA_LSB = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IN_W-1:0]         data_in,
    input  logic [BIDIR_W-1:0]      bidir_in,
    output logic [BIDIR_W-1:0]      bidir_out,
    output logic [BIDIR_W-1:0]      bidir_oe,
    output logic [L2_IN+L2_N-1:0]   result
);
    localparam int TH1 = IN_W / 2;
    localparam int TH2 = L2_IN / 2;

    logic [L1_N*IN_W-1:0]  l1_w_flat;
    logic [L2_N*L2_IN-1:0] l2_w_flat;
    logic [L1_N-1:0]       l1_fire;
    logic [L2_N-1:0]       l2_fire;
    logic                  unused_bits;

    // The port stays an input.
    assign bidir_out = '0;
    assign bidir_oe  = '0;

    // Weight storage and load sequencing.
    bnn_weight_loader #(
        .L1_N(L1_N), .L1_W(IN_W), .L2_N(L2_N), .L2_W(L2_IN), .NIB_W(NIB_W)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (bidir_in[EN_BIT]),
        .load_nib  (bidir_in[DATA_LSB +: NIB_W]),
        .l1_w_flat (l1_w_flat),
        .l2_w_flat (l2_w_flat)
    );

    // First layer on the raw input.
    bnn_layer #(.N(L1_N), .W(IN_W), .TH(TH1)) u_layer1 (
        .x      (data_in),
        .w_flat (l1_w_flat),
        .fire   (l1_fire)
    );

    // Second layer on the low first-layer neurons.
    bnn_layer #(.N(L2_N), .W(L2_IN), .TH(TH2)) u_layer2 (
        .x      (l1_fire[L2_IN-1:0]),
        .w_flat (l2_w_flat),
        .fire   (l2_fire)
    );

    // Port bits with no function and neurons nobody reads.
    assign unused_bits = ^{bidir_in[EN_BIT-1:0], l1_fire[L1_N-1:L2_IN]};

    // Output register: debug neurons above, classes below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else begin
            result <= {l1_fire[L2_IN-1:0], l2_fire};
        end
    end

    // R4
    debug_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (result[L2_N +: L2_IN] == $past(l1_fire[L2_IN-1:0])));

    // R4
    class_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (result[L2_N-1:0] == $past(l2_fire)));

endmodule

// File: tb/sim_bnn_classifier.sv
module sim_bnn_classifier;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_in = '0;
    logic [7:0] bidir_in = '0;
    logic [7:0] bidir_out, bidir_oe, result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m1 [8];
    logic [3:0] m2 [4];
    int mslot;

    // input, expected result with default weights (R9)
    localparam logic [15:0] VEC [4] = '{16'h0F73, 16'hF0CE, 16'h00FF, 16'h8119};
    localparam logic [7:0]  PROBE [8] = '{8'h00, 8'h0F, 8'hF0, 8'h81,
                                          8'h5A, 8'h3C, 8'hC3, 8'hA5};

    always #2 clk = ~clk;

    bnn_classifier u0 (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .bidir_in(bidir_in),
        .bidir_out(bidir_out), .bidir_oe(bidir_oe), .result(result)
    );

    function automatic logic [7:0] model(input logic [7:0] x);
        logic [3:0] h, c;
        int n;
        for (int i = 0; i < 4; i++) begin
            n = 0;
            for (int b = 0; b < 8; b++) n += (x[b] == m1[i][b]) ? 1 : 0;
            h[i] = (n >= 4);
        end
        for (int k = 0; k < 4; k++) begin
            n = 0;
            for (int b = 0; b < 4; b++) n += (h[b] == m2[k][b]) ? 1 : 0;
            c[k] = (n >= 2);
        end
        return {h, c};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_defaults();
        for (int i = 0; i < 8; i++) m1[i] = (8'h0F << i) | (8'h0F >> (8 - i));
        for (int k = 0; k < 4; k++) m2[k] = (4'h3 << k) | (4'h3 >> (4 - k));
        mslot = 0;
    endtask

    task automatic infer(input logic [7:0] x, input string req);
        @(negedge clk);
        bidir_in = 8'h00;
        data_in  = x;
        @(negedge clk);
        check(req, result, model(x));
    endtask

    task automatic load(input logic [3:0] nib);
        @(negedge clk);
        bidir_in = {nib, 4'b1000};
        if (mslot < 16) begin
            if (mslot % 2 == 0) m1[mslot/2][3:0] = nib;
            else                m1[mslot/2][7:4] = nib;
        end else begin
            m2[mslot-16] = nib;
        end
        mslot = (mslot + 1) % 20;
    endtask

    task automatic do_reset();
        @(negedge clk);
        bidir_in = 8'h00;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset result", result, 8'h00);
        rst_n = 1'b1;
        model_defaults();
    endtask

    task automatic probe_all(input string req);
        for (int p = 0; p < 8; p++) infer(PROBE[p], req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        model_defaults();
        // R1: reset state
        do_reset();
        // R8: port never drives
        check("R8 bidir_oe", bidir_oe, 8'h00);
        check("R8 bidir_out", bidir_out, 8'h00);

        // R9, R2, R3: default-weight vector table
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            data_in = VEC[v][15:8];
            @(negedge clk);
            check("R9 default classification", result, VEC[v][7:0]);
        end

        // R4: one-cycle register latency
        infer(8'h0F, "R4 latency setup");
        @(negedge clk);
        data_in = 8'hF0;
        #1 check("R4 holds until edge", result, 8'h73);
        @(negedge clk);
        check("R4 updates after edge", result, 8'hCE);

        // R5, R2, R3: full reload of all 20 slots
        for (int s = 0; s < 20; s++) load(4'(s * 7 + 3));
        probe_all("R5 full reload");

        // R6: paused load with garbage data
        for (int s = 0; s < 3; s++) load(4'(s * 5 + 9));
        for (int g = 0; g < 4; g++) begin
            @(negedge clk);
            bidir_in = 8'hA5;
        end
        probe_all("R6 pause ignores data");
        for (int s = 0; s < 17; s++) load(4'(s * 3 + 1));
        probe_all("R6 resume after pause");

        // R7: writes past slot 19 wrap to slot 0
        for (int s = 0; s < 3; s++) load(4'(s + 12));
        probe_all("R7 wrap to slot 0");

        // R1: reset during a load restores defaults and slot 0
        for (int s = 0; s < 5; s++) load(4'(s + 2));
        do_reset();
        for (int v = 0; v < 4; v++) infer(VEC[v][15:8], "R1 defaults after reset");
        load(4'h0);
        load(4'h0);
        probe_all("R1 slot 0 after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule